// File: doc/BRIEF.md
# Direct-Input Hold Pulse Stretcher

This block lets twenty status lines light fixed cells of a 4-common by 11-segment LCD with no bus traffic. Each line is active high. A rising edge on a line starts driving its cell. The cell stays lit as long as the line is high. It also stays lit for a minimum time, even when the line drops sooner, so that short activity pulses from a disk or similar source remain visible.

The block runs from the 32.768 kHz display clock. Each line passes through a two-flop synchroniser and then an edge detector. A rising edge loads a small per-line counter with five. The counter steps down on a shared tick whose period is one quarter of the hold time. A two-bit hold select chooses that hold time: 1x, 2x, 4x or 8x a base quarter period. Because the first tick after the edge can land anywhere within one quarter period, the stretch always falls between four and five quarter periods.

The output is a 44-bit force-on vector, bit index = 4 × segment + common. A neighbouring display stage ORs this vector into its own lighting data.

Top module: `lcd_direct_hold`

## Requirements
- R1: Line k (0..19) drives only output bit 24+k, which is segment 6+k/4, common k mod 4, under the indexing bit = 4·segment + common.
- R2: Output bits 0 to 23 are always zero.
- R3: A line that goes high sets its output bit after two clock edges, and the bit stays set for as long as the line stays high.
- R4: A short high pulse on a line keeps its output bit set for between 4·Q and 5·Q+2 clock cycles, where Q is the quarter period.
- R5: When a line drops after its hold has expired, its output bit clears within three clock cycles.
- R6: A new rising edge on a line whose cell is already held restarts the full hold from that edge.
- R7: While rst_n is low, every output bit is zero and all hold counters are cleared.
- R8: hold_sel values 0, 1, 2 and 3 give Q = BASE_QTR, 2·BASE_QTR, 4·BASE_QTR and 8·BASE_QTR cycles. With a 32.768 kHz clock and BASE_QTR = 1024, the hold windows are 0.125–0.156 s, 0.25–0.313 s, 0.5–0.625 s and 1.0–1.25 s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock (32.768 kHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 20 | Asynchronous active-high status lines |
| hold_sel | input | 2 | Hold time select, Q = BASE_QTR << hold_sel |
| force_on | output | 44 | Cell force-on vector, bit = 4·segment + common |

## Verification
The assertions assume three things about the inputs:
- hold_sel is a static strap that does not change while any cell is held.
- Every level on a line lasts at least one clock period, so the synchroniser sees it.
- Reset is applied only after time zero, so the asynchronous clear actually fires.

The stimulus respects all three:
- hold_sel changes only while the output vector is idle.
- Inputs change only at falling clock edges and stay in place for at least two cycles.
- Reset is pulled low a few nanoseconds into the run.

The bench shortens the base quarter period so that every hold select can be timed cycle by cycle.

// File: rtl/lcd_direct_hold.sv
module lcd_direct_hold #(
  parameter int N_IN      = 20,
  parameter int N_COM     = 4,
  parameter int N_SEG     = 11,
  parameter int SEG_BASE  = 6,
  parameter int BASE_QTR  = 1024,
  parameter int HOLD_LOAD = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        din,
  input  logic [1:0]             hold_sel,
  output logic [N_COM*N_SEG-1:0] force_on
);
  localparam int QW       = $clog2(BASE_QTR);
  localparam int PW       = QW + 3;
  localparam int CW       = $clog2(HOLD_LOAD + 1);
  localparam int FW       = N_COM * N_SEG;
  localparam int BASE_BIT = SEG_BASE * N_COM;

  logic [N_IN-1:0]    s1, s2, s3;
  logic [N_IN-1:0]    rise, held;
  logic [N_IN*CW-1:0] cnt_q;
  logic [PW-1:0]      pre, lim;
  logic               tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  assign lim  = ({{(PW-1){1'b0}}, 1'b1} << (QW + int'(hold_sel))) - 1'b1;
  assign tick = (pre & lim) == lim;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 cnt <= '0;
      else if (rise[i])           cnt <= CW'(HOLD_LOAD);
      else if (tick && cnt != '0) cnt <= cnt - 1'b1;
    assign cnt_q[i*CW +: CW] = cnt;
    assign held[i] = s2[i] | (cnt != '0);
  end

  assign force_on = FW'(held) << BASE_BIT;
endmodule

// File: rtl/lcd_direct_hold_chk.sv
module lcd_direct_hold_chk #(
  parameter int N_IN      = 20,
  parameter int CW        = 3,
  parameter int FW        = 44,
  parameter int BASE_BIT  = 24,
  parameter int HOLD_LOAD = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  rise,
  input logic [N_IN*CW-1:0] cnt_q,
  input logic [FW-1:0]    force_on
);
  a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    force_on[BASE_BIT-1:0] == '0);

  a_r7_reset_clear: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> force_on == '0);

  for (genvar i = 0; i < N_IN; i++) begin : g_chk
    a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i*CW +: CW] != '0) |-> force_on[BASE_BIT+i]);
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> cnt_q[i*CW +: CW] == CW'(HOLD_LOAD));
    a_r4_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i*CW +: CW] != '0 && !rise[i]) |=> cnt_q[i*CW +: CW] <= $past(cnt_q[i*CW +: CW]));
  end
endmodule

bind lcd_direct_hold lcd_direct_hold_chk #(
  .N_IN(N_IN), .CW(CW), .FW(FW), .BASE_BIT(BASE_BIT), .HOLD_LOAD(HOLD_LOAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .cnt_q(cnt_q), .force_on(force_on)
);

// File: tb/lcd_direct_hold_tb.sv
module lcd_direct_hold_tb;
  localparam int BQ = 8;

  logic        clk = 0;
  logic        rst_n = 1;
  logic [19:0] din = '0;
  logic [1:0]  hold_sel = 2'd0;
  logic [43:0] force_on;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  lcd_direct_hold #(.BASE_QTR(BQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .hold_sel(hold_sel), .force_on(force_on)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic short_pulse(input int k, output int dur, output logic [43:0] first);
    @(negedge clk) din[k] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    din[k] = 1'b0;
    first = force_on;
    dur = 0;
    while (force_on[24+k] && dur < 2000) begin
      dur++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(force_on == '0, "R7 reset state", force_on, 0);
  endtask

  task automatic t_map;
    int k_list[4] = '{0, 3, 4, 19};
    int dur;
    logic [43:0] first;
    hold_sel = 2'd0;
    foreach (k_list[j]) begin
      short_pulse(k_list[j], dur, first);
      check(first == (44'd1 << (24 + k_list[j])), "R1 mapping", first, 44'd1 << (24 + k_list[j]));
      check(first[23:0] == '0, "R2 low bits", first[23:0], 0);
    end
  endtask

  task automatic t_hold_sel;
    int dur, q;
    logic [43:0] first;
    for (int s = 0; s < 4; s++) begin
      hold_sel = 2'(s);
      q = BQ << s;
      short_pulse(5, dur, first);
      check(dur >= 4*q && dur <= 5*q + 2, "R4/R8 hold window", dur, 4*q);
    end
    hold_sel = 2'd0;
  endtask

  task automatic t_long_high;
    int q = BQ;
    int lows = 0;
    int fall;
    hold_sel = 2'd0;
    @(negedge clk) din[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(force_on[33] == 1'b1, "R3 rise after two edges", force_on[33], 1);
    for (int c = 0; c < 10*q; c++) begin
      if (!force_on[33]) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R3 held while input high", lows, 0);
    din[9] = 1'b0;
    fall = 0;
    while (force_on[33] && fall < 50) begin
      fall++;
      @(negedge clk);
    end
    check(fall >= 1 && fall <= 3, "R5 release after input low", fall, 2);
  endtask

  task automatic t_retrigger;
    int q = BQ;
    int dur;
    logic [43:0] first;
    hold_sel = 2'd0;
    @(negedge clk) din[12] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    din[12] = 1'b0;
    repeat (3*q) @(negedge clk);
    check(force_on[36] == 1'b1, "R6 still held before retrigger", force_on[36], 1);
    short_pulse(12, dur, first);
    check(dur >= 4*q && dur <= 5*q + 2, "R6 full hold after retrigger", dur, 4*q);
  endtask

  task automatic t_reset_mid;
    hold_sel = 2'd3;
    @(negedge clk) din[2] = 1'b1;
    din[17] = 1'b1;
    repeat (4) @(negedge clk);
    din = '0;
    @(negedge clk) rst_n = 1'b0;
    #1;
    check(force_on == '0, "R7 clear during hold", force_on, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(force_on == '0, "R7 counters cleared", force_on, 0);
    hold_sel = 2'd0;
  endtask

  initial begin
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_map();
    t_hold_sel();
    t_long_high();
    t_retrigger();
    t_reset_mid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule